// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block carries single words between two ports that run on independent clocks, without going through any queue. One mailbox register carries a word from port A to port B, the other carries a word from port B to port A. Each mailbox has an active-low "mail pending" flag. A write in the sending domain sets it, and a read in the receiving domain clears it. While mail is pending, further writes to that mailbox are refused, so the stored word cannot change under the reader.

Each flag is visible in both domains. The sender's copy goes low on the clock edge that accepts the write. It stays low until the receiver's clear has crossed back through a synchronizer. The receiver's copy goes low once the write event has crossed forward, and goes high on the edge that performs the read. Both events cross as toggles through multi-flop synchronizers. The mailbox data is held in a register that only a write can change, and no write is accepted while the sender's flag is low, so the receiver samples a static word.

Port A addresses a mailbox with a dedicated select input. Port B has no select input: it addresses a mailbox when its two-bit size field equals binary 11. Port A always presents the contents of the B-to-A mailbox, and port B always presents the contents of the A-to-B mailbox. Both domains take the same synchronous, active-high reset, which must be held across several edges of each clock.

Top module: `mbox_pair`

## Requirements
- R1: While `rst` is held, and after it is released with no operation, all four flag outputs are 1 and both data outputs are 0.
- R2: A port-A edge with `a_en`=1, `a_wr`=1, `a_mbx`=1 and `mb1_a_n`=1 loads `a_wdata` into the A-to-B mailbox and makes `mb1_a_n` 0 from that edge.
- R3: A port-A mailbox write while `mb1_a_n`=0 is ignored: the word on `b_rdata` keeps its earlier value.
- R4: A port-B edge with `b_en`=1, `b_wr`=0, `b_size`=2'b11 and `mb1_b_n`=0 makes `mb1_b_n` 1 from that edge. `mb1_a_n` returns to 1 within three later port-A edges.
- R5: A port-B edge with `b_en`=1, `b_wr`=1, `b_size`=2'b11 and `mb2_b_n`=1 loads `b_wdata` into the B-to-A mailbox and makes `mb2_b_n` 0 from that edge.
- R6: A port-B mailbox write while `mb2_b_n`=0 is ignored: the word on `a_rdata` keeps its earlier value.
- R7: A port-A edge with `a_en`=1, `a_wr`=0, `a_mbx`=1 and `mb2_a_n`=0 makes `mb2_a_n` 1 from that edge. `mb2_b_n` returns to 1 within three later port-B edges.
- R8: The receiver's flag (`mb1_b_n` or `mb2_a_n`) goes to 0 within three receiver edges after the accepting write edge. The written word is on the receiver's data output (`b_rdata` or `a_rdata`) and stays unchanged while that flag is 0.
- R9: Operations with `a_mbx`=0, with `b_size` other than 2'b11, or with the enable at 0 change no flag and no mailbox word.
- R10: After the receiver's read, the sender's flag stays 0 until the clear has been synchronized. The sender therefore cannot write again on the edge of the read, nor on the next sender edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| a_en | input | 1 | Port A operation enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Word written into the A-to-B mailbox |
| a_rdata | output | 36 | Contents of the B-to-A mailbox |
| mb1_a_n | output | 1 | A-to-B mail pending, sender view, active low |
| mb2_a_n | output | 1 | B-to-A mail pending, receiver view, active low |
| b_en | input | 1 | Port B operation enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_size | input | 2 | Port B size field; 2'b11 selects the mailboxes |
| b_wdata | input | 36 | Word written into the B-to-A mailbox |
| b_rdata | output | 36 | Contents of the A-to-B mailbox |
| mb1_b_n | output | 1 | A-to-B mail pending, receiver view, active low |
| mb2_b_n | output | 1 | B-to-A mail pending, sender view, active low |

## Verification
The sender's flag and the mailbox word change on the accepting edge itself, so the bench checks them at the falling edge that follows. A receiver's clear is also visible at its own next falling edge. A crossing into the other domain takes two synchronizer flops, so it is due by the second edge of the far clock. The bench samples it only after the third far-clock edge, at a falling edge. It checks the sender flag that has not yet been released half a receiver period after the read, which is too short for two sender edges to occur. The random phase waits six edges of each clock after every operation. Only then does it compare all four flags and both words with its own model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_W      = 36;
  localparam int unsigned SIZE_W      = 2;
  localparam logic [SIZE_W-1:0] SIZE_MBOX = 2'b11;

  function automatic logic size_selects_mbox(input logic [SIZE_W-1:0] sz);
    return sz == SIZE_MBOX;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int unsigned W           = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] mail_q,
  output logic         wr_flag_n,
  output logic         rd_flag_n
);
  // sending domain
  logic wtog, rtog_at_w, pend_w, wr_take;
  // receiving domain
  logic rtog, wtog_at_r, pend_r, rd_take;

  assign pend_w  = wtog ^ rtog_at_w;
  assign wr_take = wr_req & ~pend_w;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wtog   <= 1'b0;
      mail_q <= '0;
    end else if (wr_take) begin
      wtog   <= ~wtog;
      mail_q <= wr_data;
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_fwd (
    .clk (rclk),
    .rst (rst),
    .d   (wtog),
    .q   (wtog_at_r)
  );

  assign pend_r  = wtog_at_r ^ rtog;
  assign rd_take = rd_req & pend_r;

  always_ff @(posedge rclk) begin
    if (rst)          rtog <= 1'b0;
    else if (rd_take) rtog <= ~rtog;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_back (
    .clk (wclk),
    .rst (rst),
    .d   (rtog),
    .q   (rtog_at_w)
  );

  assign wr_flag_n = ~pend_w;
  assign rd_flag_n = ~pend_r;

  AST_WRITE_SETS_FLAG: assert property (@(posedge wclk) disable iff (rst)
    (wr_req && wr_flag_n) |=> !wr_flag_n);                      // R2, R5
  AST_WORD_HELD_WHILE_PENDING: assert property (@(posedge wclk) disable iff (rst)
    !wr_flag_n |=> $stable(mail_q));                            // R3, R6
  AST_READ_CLEARS_FLAG: assert property (@(posedge rclk) disable iff (rst)
    (rd_req && !rd_flag_n) |=> rd_flag_n);                      // R4, R7
  AST_RECEIVER_SEES_STABLE_WORD: assert property (@(posedge rclk) disable iff (rst)
    (!rd_flag_n && !rd_req) |=> $stable(mail_q));               // R8
  AST_SENDER_HELD_ON_READ: assert property (@(posedge rclk) disable iff (rst)
    (rd_req && !rd_flag_n) |-> !wr_flag_n);                     // R10
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W      = MBOX_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              mb1_a_n,
  output logic              mb2_a_n,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [SIZE_W-1:0] b_size,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              mb1_b_n,
  output logic              mb2_b_n
);
  logic a_sel, b_sel;
  logic a_put, a_get, b_put, b_get;

  assign a_sel = a_en & a_mbx;
  assign b_sel = b_en & size_selects_mbox(b_size);
  assign a_put = a_sel &  a_wr;
  assign a_get = a_sel & ~a_wr;
  assign b_put = b_sel &  b_wr;
  assign b_get = b_sel & ~b_wr;

  // A to B
  mbox_chan #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .wclk      (clk_a),
    .rclk      (clk_b),
    .rst       (rst),
    .wr_req    (a_put),
    .wr_data   (a_wdata),
    .rd_req    (b_get),
    .mail_q    (b_rdata),
    .wr_flag_n (mb1_a_n),
    .rd_flag_n (mb1_b_n)
  );

  // B to A
  mbox_chan #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .wclk      (clk_b),
    .rclk      (clk_a),
    .rst       (rst),
    .wr_req    (b_put),
    .wr_data   (b_wdata),
    .rd_req    (a_get),
    .mail_q    (a_rdata),
    .wr_flag_n (mb2_b_n),
    .rd_flag_n (mb2_a_n)
  );

  AST_RESET_FLAGS_HIGH_A: assert property (@(posedge clk_a)
    $past(rst) |-> (mb1_a_n && mb2_a_n));                       // R1
  AST_UNSELECTED_B_NO_CLEAR: assert property (@(posedge clk_b) disable iff (rst)
    (!b_sel && !mb1_b_n) |=> !mb1_b_n);                         // R9
endmodule

// File: tb/mbox_pair_tb.sv
module mbox_pair_tb;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W = 36;
  localparam int N_RAND = 300;

  logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
  logic a_en = 0, a_wr = 0, a_mbx = 0;
  logic b_en = 0, b_wr = 0;
  logic [1:0] b_size = 2'b00;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic mb1_a_n, mb2_a_n, mb1_b_n, mb2_b_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit m1_pend = 0, m2_pend = 0;
  logic [W-1:0] m1_word = '0, m2_word = '0;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  mbox_pair u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .mb1_a_n(mb1_a_n), .mb2_a_n(mb2_a_n),
    .b_en(b_en), .b_wr(b_wr), .b_size(b_size), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .mb1_b_n(mb1_b_n), .mb2_b_n(mb2_b_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()} & {W{1'b1}};
  endfunction

  task automatic op_a(input bit en, input bit wr, input bit mbx, input logic [W-1:0] d);
    @(negedge clk_a);
    a_en = en; a_wr = wr; a_mbx = mbx; a_wdata = d;
    @(negedge clk_a);
    a_en = 0; a_wr = 0; a_mbx = 0;
    if (en && mbx && wr && !m1_pend) begin m1_pend = 1; m1_word = d; end
    if (en && mbx && !wr) m2_pend = 0;
  endtask

  task automatic op_b(input bit en, input bit wr, input logic [1:0] sz, input logic [W-1:0] d);
    @(negedge clk_b);
    b_en = en; b_wr = wr; b_size = sz; b_wdata = d;
    @(negedge clk_b);
    b_en = 0; b_wr = 0; b_size = 2'b00;
    if (en && sz == 2'b11 && wr && !m2_pend) begin m2_pend = 1; m2_word = d; end
    if (en && sz == 2'b11 && !wr) m1_pend = 0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk_a);
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
  endtask

  task automatic check_model(input string req);
    chk({req, " mb1_a_n"}, W'(mb1_a_n), W'(!m1_pend));
    chk({req, " mb1_b_n"}, W'(mb1_b_n), W'(!m1_pend));
    chk({req, " mb2_a_n"}, W'(mb2_a_n), W'(!m2_pend));
    chk({req, " mb2_b_n"}, W'(mb2_b_n), W'(!m2_pend));
    chk({req, " b_rdata"}, b_rdata, m1_word);
    chk({req, " a_rdata"}, a_rdata, m2_word);
  endtask

  initial begin
    #(CLK_B_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    void'($urandom(32'd1234));
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
    check_model("R1 in reset");
    rst = 0;
    settle();
    check_model("R1 after reset");

    // A to B: write, crossing, blocked write, read
    x = 36'h9_A5A5_1234;
    op_a(1, 1, 1, x);
    chk("R2 sender flag low", W'(mb1_a_n), '0);
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    chk("R8 receiver flag low", W'(mb1_b_n), '0);
    chk("R8 word visible", b_rdata, x);
    op_a(1, 1, 1, 36'h1_0000_FFFF);
    settle();
    chk("R3 blocked write keeps word", b_rdata, x);
    op_b(1, 0, 2'b11, '0);
    chk("R4 receiver flag cleared", W'(mb1_b_n), W'(1));
    chk("R10 sender flag still low", W'(mb1_a_n), '0);
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    chk("R4 sender flag released", W'(mb1_a_n), W'(1));
    settle();
    check_model("R4 settled");

    // B to A
    y = 36'h3_C3C3_0F0F;
    op_b(1, 1, 2'b11, y);
    chk("R5 sender flag low", W'(mb2_b_n), '0);
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    chk("R8 receiver flag low", W'(mb2_a_n), '0);
    chk("R8 word visible", a_rdata, y);
    op_b(1, 1, 2'b11, 36'hF_FFFF_0000);
    settle();
    chk("R6 blocked write keeps word", a_rdata, y);

    // unselected operations while both mailboxes hold mail
    op_a(1, 1, 1, 36'h0_1111_2222);
    settle();
    op_b(1, 0, 2'b10, '0);
    op_b(1, 0, 2'b01, '0);
    op_b(0, 0, 2'b11, '0);
    op_a(1, 0, 0, '0);
    op_a(0, 0, 1, '0);
    op_a(1, 1, 0, 36'h2_2222_3333);
    op_b(1, 1, 2'b00, 36'h4_4444_5555);
    settle();
    check_model("R9 unselected ops");

    op_a(1, 0, 1, '0);
    chk("R7 receiver flag cleared", W'(mb2_a_n), W'(1));
    repeat (3) @(posedge clk_b);
    @(negedge clk_b);
    chk("R7 sender flag released", W'(mb2_b_n), W'(1));
    settle();
    check_model("R7 settled");

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      int unsigned sel;
      sel = $urandom % 7;
      case (sel)
        0: op_a(1, 1, 1, rnd_word());
        1: op_a(1, 0, 1, '0);
        2: op_a($urandom % 2, $urandom % 2, 0, rnd_word());
        3: op_b(1, 1, 2'b11, rnd_word());
        4: op_b(1, 0, 2'b11, '0);
        5: op_b(1, $urandom % 2, 2'($urandom % 3), rnd_word());
        default: op_b(0, $urandom % 2, 2'b11, rnd_word());
      endcase
      settle();
      check_model("R2/R3/R5/R6/R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule